// File: doc/BRIEF.md
# Dual-Input Scaled Feedback Combiner

This block is a two-stage streaming datapath. It takes two signed converter samples and produces one signed output sample for a digital-to-analog converter. Each input is multiplied by its own run-time gain. The gain is a signed fixed-point value with one integer bit, so it covers the range -1.0 to just under +1.0. The product is rounded back to the sample width. The scaled second input then runs through a delay line whose length in clock cycles is set at run time. Two mode bits decide what reaches the output:
- Double-input mode adds the delayed second input to the scaled first input, or subtracts it.
- Single-input mode forwards only the scaled first input, inverted when subtraction is selected.

Every result clamps to the sample range instead of wrapping. The mode, gain and delay settings are sampled together with the input sample they belong to, so a change mid-stream never splits a sample. Four peak-magnitude registers watch the stream for debug: both raw inputs, the scaled first input and the final output. A clear input empties these registers without touching the data path.

Top module: `fb_combiner`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_s` is 0 and all four peak outputs are 0.
- R2: `out_valid` is asserted exactly two clock edges after the edge that samples `in_valid` high, and is low two edges after one that samples it low. `out_s` changes only when a valid result is delivered.
- R3: A gain `g` (GW bits, two's complement) stands for g / 2^(GW-1). A scaled sample is floor((x*g + 2^(GW-2)) / 2^(GW-1)), which rounds halves upward, clamped to [-2^(SW-1), 2^(SW-1)-1].
- R4: With `cfg_dual`=0 and `cfg_add`=1, `out_s` equals the scaled first input.
- R5: With `cfg_dual`=0 and `cfg_add`=0, `out_s` equals the scaled first input negated, then clamped.
- R6: With `cfg_dual`=1, `out_s` equals the scaled first input plus (`cfg_add`=1) or minus (`cfg_add`=0) the delayed scaled second input.
- R7: The delayed term is the scaled second input from `cfg_delay` clock cycles earlier, and `cfg_delay`=0 means no delay. The line advances every clock, and a cycle with `in_valid` low contributes zero.
- R8: `cfg_add`, `cfg_dual`, `cfg_delay`, `gain1` and `gain2` are taken in the same cycle as the sample they accompany. Changing them on every sample gives each result exactly its own settings.
- R9: A sum or difference outside the sample range clamps to the nearest limit, so two positive terms never produce a negative output.
- R10: `peak_in1` and `peak_in2` hold the largest magnitude of any valid raw input, `peak_scaled` that of any valid scaled first input, and `peak_out` that of any delivered output. They never decrease unless cleared.
- R11: `peak_clr_n` low at an edge zeroes all four peaks. In the same edge it overrides any update, and it has no effect on `out_s` or `out_valid`.
- R12: Reset empties the delay history, so delayed terms read zero until the line has been refilled after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe for `in1_s`/`in2_s` |
| in1_s | input | SW | First input sample, signed |
| in2_s | input | SW | Second input sample, signed |
| gain1 | input | GW | Gain for the first input, signed, one integer bit |
| gain2 | input | GW | Gain for the second input, signed, one integer bit |
| cfg_add | input | 1 | 1 = add, 0 = subtract or invert |
| cfg_dual | input | 1 | 1 = combine both inputs, 0 = first input only |
| cfg_delay | input | DW | Delay of the second input in clock cycles |
| peak_clr_n | input | 1 | Active-low clear of the peak registers |
| out_valid | output | 1 | Output sample strobe |
| out_s | output | SW | Output sample, signed |
| peak_in1 | output | SW | Largest magnitude seen on the first input |
| peak_in2 | output | SW | Largest magnitude seen on the second input |
| peak_scaled | output | SW | Largest magnitude of the scaled first input |
| peak_out | output | SW | Largest magnitude of the output |

## Verification
A peak clear and a sample that would raise a peak can land on the same clock edge. Samples still in flight can also reach the peak registers on that edge. The bench provokes this by asserting `peak_clr_n` low in the same cycle as a full-scale valid sample. It then expects the input peaks to stay zero, while the scaled and output peaks of that same sample appear one and two edges later. The second overlap is a configuration change landing on every sample while delayed terms from earlier settings are still in the line. A per-cycle model of the delay history judges that case.

// File: rtl/fb_pkg.sv
`timescale 1ns/1ps
// Shared types for the feedback combiner.
// Assumes nothing beyond a standard SystemVerilog elaborator.
package fb_pkg;

    // Operation selection carried alongside each sample.
    typedef struct packed {
        logic add;   // 1 = add, 0 = subtract / invert
        logic dual;  // 1 = both inputs, 0 = first input only
    } fb_mode_t;

    // Number of peak trackers in the block.
    localparam int NUM_PEAKS = 4;

endpackage

// File: rtl/fb_scaler.sv
`timescale 1ns/1ps
// Multiplies a signed sample by a signed gain with one integer bit,
// rounds halves upward and clamps the result back to the sample width.
// Purely combinational. Assumes GW >= 2.
module fb_scaler #(
    parameter int SW = 8,
    parameter int GW = 8
) (
    input  logic signed [SW-1:0] x,
    input  logic signed [GW-1:0] g,
    output logic signed [SW-1:0] y
);
    localparam int PW = SW + GW;
    localparam logic signed [PW-1:0] HALF = PW'(1 << (GW-2));
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (SW-1)) - 1);
    localparam logic signed [PW-1:0] MINV = PW'(-(1 << (SW-1)));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] shr;

    // Full product, rounding offset, shift back and clamp.
    always_comb begin
        prod = x * g;
        rnd  = prod + HALF;
        shr  = rnd >>> (GW-1);
        if (shr > MAXV)      y = MAXV[SW-1:0];
        else if (shr < MINV) y = MINV[SW-1:0];
        else                 y = shr[SW-1:0];
    end

endmodule

// File: rtl/fb_delay.sv
`timescale 1ns/1ps
// Circular delay line that advances one entry per clock.
// dout is din from dly cycles earlier; dly = 0 passes din through.
// Reset clears the stored history. Depth is 2^DW, so the longest delay
// is 2^DW-1.
module fb_delay #(
    parameter int SW = 8,
    parameter int DW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [SW-1:0] din,
    input  logic        [DW-1:0] dly,
    output logic signed [SW-1:0] dout
);
    localparam int DEPTH = 1 << DW;

    logic signed [SW-1:0] mem [DEPTH];
    logic        [DW-1:0] wptr;
    logic        [DW-1:0] rptr;

    // Write the current value each clock and advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            mem[wptr] <= din;
            wptr      <= wptr + 1'b1;
        end
    end

    // Select the entry written dly cycles ago, or bypass for zero.
    always_comb begin
        rptr = wptr - dly;
        dout = (dly == '0) ? din : mem[rptr];
    end

endmodule

// File: rtl/fb_peak.sv
`timescale 1ns/1ps
// Tracks the largest magnitude of a signed value on cycles where upd is
// high. A low clr_n zeroes it and wins over a same-cycle update.
// The magnitude of the most negative value fits in SW unsigned bits.
module fb_peak #(
    parameter int SW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_n,
    input  logic                 upd,
    input  logic signed [SW-1:0] val,
    output logic        [SW-1:0] peak
);
    logic [SW-1:0] mag;

    // Two's-complement magnitude.
    always_comb begin
        mag = val[SW-1] ? (~val + 1'b1) : val;
    end

    // Hold the maximum, with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            peak <= '0;
        end else if (upd && (mag > peak)) begin
            peak <= mag;
        end
    end

    // R11: a clear leaves the register at zero.
    p_peak_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (peak == '0));

    // R10: without a clear the peak never falls.
    p_peak_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n |=> (peak >= $past(peak)));

endmodule

// File: rtl/fb_combiner.sv
`timescale 1ns/1ps
// Dual-input scaled feedback combiner.
// Stage 1 scales both inputs and registers them with their settings.
// Stage 2 delays the second term, then adds, subtracts or inverts, and
// clamps. Latency is two edges. Four peak trackers watch the stream.
// Assumes a synchronous active-low reset and GW >= 2.
module fb_combiner
    import fb_pkg::*;
#(
    parameter int SW = 8,
    parameter int GW = 8,
    parameter int DW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in1_s,
    input  logic signed [SW-1:0] in2_s,
    input  logic signed [GW-1:0] gain1,
    input  logic signed [GW-1:0] gain2,
    input  logic                 cfg_add,
    input  logic                 cfg_dual,
    input  logic        [DW-1:0] cfg_delay,
    input  logic                 peak_clr_n,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_s,
    output logic        [SW-1:0] peak_in1,
    output logic        [SW-1:0] peak_in2,
    output logic        [SW-1:0] peak_scaled,
    output logic        [SW-1:0] peak_out
);
    localparam logic signed [SW:0] SMAX = (SW+1)'((1 << (SW-1)) - 1);
    localparam logic signed [SW:0] SMIN = (SW+1)'(-(1 << (SW-1)));

    logic signed [SW-1:0] scaled1, scaled2;
    logic                 s1_valid;
    logic signed [SW-1:0] s1_a, s1_b;
    fb_mode_t             s1_mode;
    logic        [DW-1:0] s1_dly;
    logic signed [SW-1:0] b_del;
    logic signed [SW:0]   ext_a, ext_b, sum;
    logic signed [SW-1:0] res;

    fb_scaler #(.SW(SW), .GW(GW)) u_scale1 (.x(in1_s), .g(gain1), .y(scaled1));
    fb_scaler #(.SW(SW), .GW(GW)) u_scale2 (.x(in2_s), .g(gain2), .y(scaled2));

    // Stage 1: capture scaled samples together with their settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_a     <= '0;
            s1_b     <= '0;
            s1_mode  <= '0;
            s1_dly   <= '0;
        end else begin
            s1_valid     <= in_valid;
            s1_a         <= in_valid ? scaled1 : '0;
            s1_b         <= in_valid ? scaled2 : '0;
            s1_mode.add  <= cfg_add;
            s1_mode.dual <= cfg_dual;
            s1_dly       <= cfg_delay;
        end
    end

    fb_delay #(.SW(SW), .DW(DW)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (s1_b),
        .dly  (s1_dly),
        .dout (b_del)
    );

    // Combine according to the mode, then clamp to the sample range.
    always_comb begin
        ext_a = {s1_a[SW-1], s1_a};
        ext_b = {b_del[SW-1], b_del};
        if (s1_mode.dual) sum = s1_mode.add ? (ext_a + ext_b) : (ext_a - ext_b);
        else              sum = s1_mode.add ? ext_a : -ext_a;
        if (sum > SMAX)      res = SMAX[SW-1:0];
        else if (sum < SMIN) res = SMIN[SW-1:0];
        else                 res = sum[SW-1:0];
    end

    // Stage 2: deliver the result; hold the output between samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_s     <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_s <= res;
        end
    end

    // Peak trackers: raw inputs, scaled first input, final output.
    logic                 pk_upd [NUM_PEAKS];
    logic signed [SW-1:0] pk_val [NUM_PEAKS];
    logic        [SW-1:0] pk_q   [NUM_PEAKS];

    // Route each watched value with the strobe that qualifies it.
    always_comb begin
        pk_upd[0] = in_valid;  pk_val[0] = in1_s;
        pk_upd[1] = in_valid;  pk_val[1] = in2_s;
        pk_upd[2] = s1_valid;  pk_val[2] = s1_a;
        pk_upd[3] = out_valid; pk_val[3] = out_s;
    end

    for (genvar k = 0; k < NUM_PEAKS; k++) begin : g_peak
        fb_peak #(.SW(SW)) u_peak (
            .clk  (clk),
            .rst_n(rst_n),
            .clr_n(peak_clr_n),
            .upd  (pk_upd[k]),
            .val  (pk_val[k]),
            .peak (pk_q[k])
        );
    end

    assign peak_in1    = pk_q[0];
    assign peak_in2    = pk_q[1];
    assign peak_scaled = pk_q[2];
    assign peak_out    = pk_q[3];

    // R2: a valid input yields a valid output two edges later.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R4: single-input add mode forwards the scaled first input.
    p_single_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_mode.dual && s1_mode.add) |=> (out_s == $past(s1_a)));

    // R9: adding two non-negative terms never wraps negative.
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_mode.dual && s1_mode.add && !s1_a[SW-1] && !b_del[SW-1])
        |=> !out_s[SW-1]);

endmodule

// File: tb/tb_fb_combiner.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps of a small configuration against an
// arithmetic per-cycle model of the datapath, delay history and peaks.
module tb_fb_combiner;
    localparam int SW = 8;
    localparam int GW = 8;
    localparam int DW = 3;
    localparam int MAXV = (1 << (SW-1)) - 1;
    localparam int MINV = -(1 << (SW-1));

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [SW-1:0] in1_s = '0, in2_s = '0;
    logic signed [GW-1:0] gain1 = '0, gain2 = '0;
    logic                 cfg_add = 1'b0, cfg_dual = 1'b0;
    logic        [DW-1:0] cfg_delay = '0;
    logic                 peak_clr_n = 1'b1;
    logic                 out_valid;
    logic signed [SW-1:0] out_s;
    logic        [SW-1:0] peak_in1, peak_in2, peak_scaled, peak_out;

    fb_combiner #(.SW(SW), .GW(GW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in1_s(in1_s), .in2_s(in2_s),
        .gain1(gain1), .gain2(gain2), .cfg_add(cfg_add), .cfg_dual(cfg_dual),
        .cfg_delay(cfg_delay), .peak_clr_n(peak_clr_n), .out_valid(out_valid),
        .out_s(out_s), .peak_in1(peak_in1), .peak_in2(peak_in2),
        .peak_scaled(peak_scaled), .peak_out(peak_out)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int hb [256];
    int ea [256];
    int ee [256];
    bit ev [256];
    int pm1, pm2, pms, pmo;

    function automatic int sat(int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic int scl(int x, int g);
        return sat((x * g + (1 << (GW-2))) >>> (GW-1));
    endfunction

    function automatic int mag(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int wrap(int v);
        return sat(((v - MINV) % (MAXV - MINV + 1)) + MINV);
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic check_peaks(string tag);
        chk(tag, "peak_in1", int'(peak_in1), pm1);
        chk(tag, "peak_in2", int'(peak_in2), pm2);
        chk(tag, "peak_scaled", int'(peak_scaled), pms);
        chk(tag, "peak_out", int'(peak_out), pmo);
    endtask

    // Hold reset, check the reset state (R1), clear the model, release.
    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; peak_clr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "out_s", int'(out_s), 0);
        chk("R1", "peak_in1", int'(peak_in1), 0);
        chk("R1", "peak_in2", int'(peak_in2), 0);
        chk("R1", "peak_scaled", int'(peak_scaled), 0);
        chk("R1", "peak_out", int'(peak_out), 0);
        for (int i = 0; i < 256; i++) begin
            hb[i] = 0; ea[i] = 0; ee[i] = 0; ev[i] = 1'b0;
        end
        pm1 = 0; pm2 = 0; pms = 0; pmo = 0; cyc = 0;
        rst_n = 1'b1;
    endtask

    // One clock cycle: drive, model, clock, then check the delivered result.
    task automatic step(bit v, int x1, int x2, int g1, int g2, bit add, bit dual,
                        int d, bit clr, bit chkpk, string tag);
        int a, b, bd, e, i, p, q;
        in_valid = v; in1_s = SW'(x1); in2_s = SW'(x2);
        gain1 = GW'(g1); gain2 = GW'(g2);
        cfg_add = add; cfg_dual = dual; cfg_delay = DW'(d); peak_clr_n = !clr;
        a = v ? scl(x1, g1) : 0;
        b = v ? scl(x2, g2) : 0;
        i = cyc & 255;
        hb[i] = b;
        bd = (d == 0) ? b : hb[(cyc - d) & 255];
        if (dual) e = sat(add ? a + bd : a - bd);
        else      e = sat(add ? a : -a);
        ev[i] = v; ea[i] = a; ee[i] = e;
        @(posedge clk);
        #2;
        p = (cyc - 1) & 255;
        q = (cyc - 2) & 255;
        if (clr) begin
            pm1 = 0; pm2 = 0; pms = 0; pmo = 0;
        end else begin
            if (v && mag(x1) > pm1) pm1 = mag(x1);
            if (v && mag(x2) > pm2) pm2 = mag(x2);
            if (ev[p] && mag(ea[p]) > pms) pms = mag(ea[p]);
            if (ev[q] && mag(ee[q]) > pmo) pmo = mag(ee[q]);
        end
        chk("R2", "out_valid", int'(out_valid), int'(ev[p]));
        if (ev[p]) chk(tag, "out_s", int'(out_s), ee[p]);
        if (chkpk) check_peaks(tag);
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) step(1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        int gl [8];
        gl = '{127, -128, 64, -64, 1, 0, -1, 85};
        @(negedge clk);
        do_reset();

        // R3: gain rounding and clamping over all inputs and several gains.
        for (int gi = 0; gi < 8; gi++)
            for (int x = MINV; x <= MAXV; x++)
                step(1'b1, x, 0, gl[gi], 0, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R3");
        // R4: single-input forwarding.
        for (int x = MINV; x <= MAXV; x++)
            step(1'b1, x, -x, 100, 127, 1'b1, 1'b0, 3, 1'b0, 1'b0, "R4");
        // R5: single-input inversion.
        for (int x = MINV; x <= MAXV; x++)
            step(1'b1, x, 0, 127, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R5");
        for (int x = MINV; x <= MAXV; x++)
            step(1'b1, x, 0, -128, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R5");
        // R6: combine both inputs, add and subtract, no delay.
        for (int m = 0; m < 2; m++)
            for (int x = MINV; x <= MAXV; x++)
                step(1'b1, x, wrap(x * 37 + 11), 127, 96, m[0], 1'b1, 0, 1'b0, 1'b0, "R6");
        // R9: clamping at both ends.
        step(1'b1, 127, 127, 127, 127, 1'b1, 1'b1, 0, 1'b0, 1'b0, "R9");
        step(1'b1, -128, -128, 127, 127, 1'b1, 1'b1, 0, 1'b0, 1'b0, "R9");
        step(1'b1, 127, -128, 127, 127, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R9");
        step(1'b1, -128, 127, 127, 127, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R9");
        step(1'b1, 100, 90, 127, 127, 1'b1, 1'b1, 0, 1'b0, 1'b0, "R9");
        // R10: peaks after the sweeps.
        idle(3, "R10");
        check_peaks("R10");
        // R7: every delay length, with gaps inserting zeros.
        for (int d = 0; d < (1 << DW); d++)
            for (int k = 0; k < 40; k++)
                step((k % 5) != 4, 0, wrap(k * 13 - 60 + d), 0, 127, 1'b1, 1'b1, d,
                     1'b0, 1'b0, "R7");
        // R8: settings changing on every sample.
        for (int k = 0; k < 400; k++)
            step(($urandom % 8) != 0, wrap(int'($urandom % 256) - 128),
                 wrap(int'($urandom % 256) - 128), int'($urandom % 256) - 128,
                 int'($urandom % 256) - 128, 1'($urandom), 1'($urandom),
                 int'($urandom % (1 << DW)), 1'b0, (k % 50) == 49, "R8");
        // R11 and R10: clear, then a known stream.
        step(1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 0, 1'b1, 1'b1, "R11");
        step(1'b1, 20, 5, 127, 127, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R10");
        step(1'b1, -90, -7, 127, 127, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R10");
        step(1'b1, 50, 100, 127, 127, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R10");
        idle(3, "R10");
        check_peaks("R10");
        chk("R10", "peak_in1 literal", int'(peak_in1), 90);
        chk("R10", "peak_scaled literal", int'(peak_scaled), 89);
        // R11: clear in the same cycle as a full-scale sample.
        step(1'b1, -128, -128, 127, 127, 1'b1, 1'b0, 0, 1'b1, 1'b1, "R11");
        idle(3, "R11");
        check_peaks("R11");
        chk("R11", "peak_in1 stays clear", int'(peak_in1), 0);
        chk("R11", "peak_out after clear", int'(peak_out), 127);
        // R12: fill the history, reset, and expect an empty line.
        for (int k = 0; k < 10; k++)
            step(1'b1, 0, 100, 0, 127, 1'b1, 1'b1, 7, 1'b0, 1'b0, "R7");
        do_reset();
        for (int k = 0; k < 10; k++)
            step(1'b1, 10, 100, 127, 127, 1'b1, 1'b1, 7, 1'b0, 1'b0, "R12");
        idle(2, "R12");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule